// File: doc/BRIEF.md
# Vector Mask and Tail Policy Unit

This unit forms the writeback image of one vector destination register for an element-wise vector operation. It gets the per-element results of the datapath already laid out as a full register image, the previous contents of the destination, the mask register and the operation controls: body length, start index, element size, mask enable and the two fill policies. It decides for every byte whether the byte takes the computed result, takes an all-ones fill, or keeps its old contents. It returns the merged register together with a byte-enable vector.

A single-cycle `start` pulse latches the merged image. One clock later the image appears on the outputs with a one-cycle `done_o` strobe. The resume index output `vstart_o` reads zero once the operation has finished. Elements below the start index are never touched. The whole operation is dropped when the start index is not below the body length.

Top module: `vmask_tail_writer`

## Requirements
- R1: `done_o` is high exactly in the cycle after a cycle with `start` high. `vd_o`, `be_o` and `vstart_o` change only on such an operation and hold their values otherwise.
- R2: A body element (vstart ≤ i < vl) that is active takes its bytes from `result_i`, and its byte enables are 1.
- R3: With `vm` = 1 every body element is active and `v0_i` has no effect.
- R4: With `vm` = 0, element i is masked off when bit i of `v0_i` is 0 (bit 0 is element 0). When `vma` = 1, every byte of a masked-off element is written to 8'hFF with its enable set.
- R5: When `vma` = 0, a masked-off element keeps its bytes from `old_vd_i` and its enables are 0.
- R6: Tail elements (vl ≤ i < total) are written to 8'hFF with their enables set when `vta` = 1. When `vta` = 0 they keep `old_vd_i` with their enables clear.
- R7: Prestart elements (i < vstart) always keep `old_vd_i` and have their enables clear.
- R8: When vstart ≥ vl, no byte is written: `be_o` is all zeros and `vd_o` equals `old_vd_i`.
- R9: After an operation `vstart_o` is 0.
- R10: `esz_i` code k (0..3) selects elements of 2^k bytes. Element i covers bytes i·2^k through (i+1)·2^k − 1, and the total element count is (VLEN/8) >> k.
- R11: After reset `done_o` is 0 and `vd_o`, `be_o` and `vstart_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | one-cycle operation request |
| vm | input | 1 | 1 = unmasked operation |
| vta | input | 1 | tail policy, 1 = fill with ones |
| vma | input | 1 | masked-off policy, 1 = fill with ones |
| esz_i | input | 2 | element size code, 2^code bytes |
| vl_i | input | $clog2(VLEN/8+1) | body length in elements |
| vstart_i | input | $clog2(VLEN/8+1) | first element to process |
| v0_i | input | VLEN | mask register, bit i for element i |
| old_vd_i | input | VLEN | previous destination contents |
| result_i | input | VLEN | computed element results, register layout |
| done_o | output | 1 | completion strobe |
| vd_o | output | VLEN | merged destination image |
| be_o | output | VLEN/8 | per-byte write enable |
| vstart_o | output | $clog2(VLEN/8+1) | resume index after the operation |

## Verification
The hardest case to produce is a single register that holds prestart, active, masked-off and tail elements all at once, at a wide element size where a mask bit must steer a whole multi-byte lane. The vector table therefore pairs nonzero start indices with partial masks, short body lengths and every element size. Each operation uses its own old and result byte patterns, so a byte taken from the wrong source shows up. The table also includes mask bits beyond vl, the empty-body cases vstart = vl, vstart > vl and vl = 0, and both values of each policy bit.

// File: rtl/vmtp_pkg.sv
package vmtp_pkg;
    // per-byte disposition computed from element position and mask
    typedef enum logic [1:0] {
        CLS_KEEP   = 2'd0,   // prestart or no-body operation
        CLS_ACTIVE = 2'd1,
        CLS_MASKED = 2'd2,
        CLS_TAIL   = 2'd3
    } byte_cls_e;

    localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/vmtp_classify.sv
module vmtp_classify
    import vmtp_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic                                vm,
    input  logic [1:0]                          esz_i,
    input  logic [$clog2(VLEN/8+1)-1:0]         vl_i,
    input  logic [$clog2(VLEN/8+1)-1:0]         vstart_i,
    input  logic [VLEN-1:0]                     v0_i,
    output byte_cls_e                           cls_o [VLEN/8]
);
    localparam int NBYTES = VLEN / 8;
    localparam int IDXW   = $clog2(NBYTES + 1);

    logic no_body;
    assign no_body = (vstart_i >= vl_i);

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic [IDXW-1:0] idx;
        assign idx = IDXW'(b) >> esz_i;

        always_comb begin
            if (no_body)                      cls_o[b] = CLS_KEEP;
            else if (idx >= vl_i)             cls_o[b] = CLS_TAIL;
            else if (idx < vstart_i)          cls_o[b] = CLS_KEEP;
            else if (!vm && !v0_i[idx])       cls_o[b] = CLS_MASKED;
            else                              cls_o[b] = CLS_ACTIVE;
        end
    end
endmodule

// File: rtl/vmtp_byte_merge.sv
module vmtp_byte_merge
    import vmtp_pkg::*;
(
    input  byte_cls_e   cls_i,
    input  logic        vta,
    input  logic        vma,
    input  logic [7:0]  old_i,
    input  logic [7:0]  res_i,
    output logic [7:0]  byte_o,
    output logic        en_o
);
    logic [7:0] src;

    always_comb begin
        unique case (cls_i)
            CLS_ACTIVE: begin en_o = 1'b1; src = res_i;     end
            CLS_MASKED: begin en_o = vma;  src = FILL_BYTE; end
            CLS_TAIL:   begin en_o = vta;  src = FILL_BYTE; end
            default:    begin en_o = 1'b0; src = old_i;     end
        endcase
        byte_o = en_o ? src : old_i;
    end
endmodule

// File: rtl/vmask_tail_writer.sv
module vmask_tail_writer
    import vmtp_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic                            vm,
    input  logic                            vta,
    input  logic                            vma,
    input  logic [1:0]                      esz_i,
    input  logic [$clog2(VLEN/8+1)-1:0]     vl_i,
    input  logic [$clog2(VLEN/8+1)-1:0]     vstart_i,
    input  logic [VLEN-1:0]                 v0_i,
    input  logic [VLEN-1:0]                 old_vd_i,
    input  logic [VLEN-1:0]                 result_i,
    output logic                            done_o,
    output logic [VLEN-1:0]                 vd_o,
    output logic [VLEN/8-1:0]               be_o,
    output logic [$clog2(VLEN/8+1)-1:0]     vstart_o
);
    localparam int NBYTES = VLEN / 8;
    localparam int IDXW   = $clog2(NBYTES + 1);

    typedef struct packed {
        logic              done;
        logic [VLEN-1:0]   vd;
        logic [NBYTES-1:0] be;
        logic [IDXW-1:0]   vstart;
    } state_t;

    state_t st_d, st_q;

    byte_cls_e         cls [NBYTES];
    logic [VLEN-1:0]   merged;
    logic [NBYTES-1:0] merged_en;

    vmtp_classify #(.VLEN(VLEN)) u_cls (
        .vm       (vm),
        .esz_i    (esz_i),
        .vl_i     (vl_i),
        .vstart_i (vstart_i),
        .v0_i     (v0_i),
        .cls_o    (cls)
    );

    for (genvar b = 0; b < NBYTES; b++) begin : g_merge
        vmtp_byte_merge u_mrg (
            .cls_i  (cls[b]),
            .vta    (vta),
            .vma    (vma),
            .old_i  (old_vd_i[8*b +: 8]),
            .res_i  (result_i[8*b +: 8]),
            .byte_o (merged[8*b +: 8]),
            .en_o   (merged_en[b])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = start;
        if (start) begin
            st_d.vd     = merged;
            st_d.be     = merged_en;
            st_d.vstart = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o   = st_q.done;
    assign vd_o     = st_q.vd;
    assign be_o     = st_q.be;
    assign vstart_o = st_q.vstart;
endmodule

// File: rtl/vmtp_checker.sv
module vmtp_checker #(
    parameter int VLEN = 128
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            start,
    input logic                            vta,
    input logic                            vma,
    input logic [$clog2(VLEN/8+1)-1:0]     vl_i,
    input logic [$clog2(VLEN/8+1)-1:0]     vstart_i,
    input logic [VLEN-1:0]                 old_vd_i,
    input logic                            done_o,
    input logic [VLEN-1:0]                 vd_o,
    input logic [VLEN/8-1:0]               be_o
);
    localparam int NBYTES = VLEN / 8;

    logic [VLEN-1:0] be_bits;
    always_comb begin
        for (int b = 0; b < NBYTES; b++) be_bits[8*b +: 8] = {8{be_o[b]}};
    end

    // R1: strobe follows a request by one cycle
    assert_done_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done_o);
    assert_no_spurious_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done_o);

    // R8: empty body writes nothing
    assert_empty_body_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (vstart_i >= vl_i)) |=> (be_o == '0));

    // R5, R7: disabled bytes carry the old contents
    assert_unwritten_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((vd_o & ~be_bits) == ($past(old_vd_i) & ~be_bits)));

    // R4, R6: both agnostic policies with a full body from zero write every byte
    assert_full_agnostic_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && vta && vma && vstart_i == '0 && vl_i != '0) |=> (be_o == '1));
endmodule

bind vmask_tail_writer vmtp_checker #(.VLEN(VLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .vta      (vta),
    .vma      (vma),
    .vl_i     (vl_i),
    .vstart_i (vstart_i),
    .old_vd_i (old_vd_i),
    .done_o   (done_o),
    .vd_o     (vd_o),
    .be_o     (be_o)
);

// File: tb/sim_vmask_tail_writer.sv
module sim_vmask_tail_writer;
    localparam int VLEN     = 128;
    localparam int NB       = VLEN / 8;
    localparam int IW       = $clog2(NB + 1);
    localparam int CLK_HALF = 5;

    logic            clk = 0, rst_n = 0, start = 0;
    logic            vm = 0, vta = 0, vma = 0;
    logic [1:0]      esz = 0;
    logic [IW-1:0]   vl = 0, vs = 0;
    logic [VLEN-1:0] v0 = 0, old_vd = 0, res = 0;
    logic            done;
    logic [VLEN-1:0] vd;
    logic [NB-1:0]   be;
    logic [IW-1:0]   vs_out;

    int checks = 0, fails = 0;

    always #CLK_HALF clk = ~clk;

    vmask_tail_writer #(.VLEN(VLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vm(vm), .vta(vta), .vma(vma),
        .esz_i(esz), .vl_i(vl), .vstart_i(vs), .v0_i(v0), .old_vd_i(old_vd),
        .result_i(res), .done_o(done), .vd_o(vd), .be_o(be), .vstart_o(vs_out)
    );

    typedef struct packed {
        logic        m, ta, ma;
        logic [1:0]  sz;
        logic [4:0]  len, st;
        logic [15:0] mask;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,2'd0,5'd16,5'd0,16'h0000}, // 0  R2 R3 all active
        '{1'b1,1'b1,1'b1,2'd0,5'd10,5'd0,16'h0000}, // 1  R3 R6 tail ones
        '{1'b0,1'b0,1'b1,2'd0,5'd16,5'd0,16'hA5A5}, // 2  R4 masked ones
        '{1'b0,1'b0,1'b0,2'd0,5'd16,5'd0,16'hA5A5}, // 3  R5 masked kept
        '{1'b0,1'b1,1'b0,2'd1,5'd5, 5'd0,16'h0015}, // 4  R10 R6 halfwords
        '{1'b0,1'b0,1'b1,2'd2,5'd3, 5'd1,16'h0002}, // 5  R7 R4 words
        '{1'b1,1'b1,1'b1,2'd3,5'd1, 5'd0,16'h0000}, // 6  R10 doublewords
        '{1'b0,1'b1,1'b1,2'd0,5'd8, 5'd8,16'h00F0}, // 7  R8 vstart == vl
        '{1'b0,1'b1,1'b1,2'd1,5'd3, 5'd5,16'hFFFF}, // 8  R8 vstart > vl
        '{1'b1,1'b0,1'b0,2'd0,5'd0, 5'd0,16'hFFFF}, // 9  R8 vl zero
        '{1'b0,1'b1,1'b1,2'd2,5'd4, 5'd0,16'hFFF6}, // 10 R4 bits beyond vl
        '{1'b0,1'b1,1'b0,2'd3,5'd2, 5'd1,16'h0000}  // 11 R7 R5 doublewords
    };

    logic [VLEN-1:0] exp_vd;
    logic [NB-1:0]   exp_be;

    task automatic chk(input logic ok, input string req,
                       input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference from the requirements
    task automatic model();
        int total, w;
        w = 1 << esz;
        total = NB >> esz;
        exp_vd = old_vd;
        exp_be = '0;
        if (vs < vl) begin
            for (int i = 0; i < total; i++) begin
                for (int k = 0; k < w; k++) begin
                    int b;
                    b = i * w + k;
                    if (i >= int'(vl)) begin
                        if (vta) begin exp_vd[8*b +: 8] = 8'hFF; exp_be[b] = 1'b1; end
                    end else if (i < int'(vs)) begin
                        // prestart untouched
                    end else if (!vm && !v0[i]) begin
                        if (vma) begin exp_vd[8*b +: 8] = 8'hFF; exp_be[b] = 1'b1; end
                    end else begin
                        exp_vd[8*b +: 8] = res[8*b +: 8];
                        exp_be[b] = 1'b1;
                    end
                end
            end
        end
    endtask

    task automatic run_op();
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(done == 1'b0 && vd == '0 && be == '0 && vs_out == '0, "R11",
            {done, vd[VLEN-2:0]}, '0);
        rst_n = 1;
        @(negedge clk);
        chk(done == 1'b0, "R1 idle", VLEN'(done), '0);

        for (int n = 0; n < NV; n++) begin
            vm  = VEC[n].m;  vta = VEC[n].ta; vma = VEC[n].ma;
            esz = VEC[n].sz; vl  = VEC[n].len; vs = VEC[n].st;
            v0  = VLEN'(VEC[n].mask);
            for (int b = 0; b < NB; b++) begin
                old_vd[8*b +: 8] = 8'(n * 29 + b * 7 + 3);
                res[8*b +: 8]    = 8'(n * 53 + b * 11 + 128);
            end
            model();
            run_op();
            $display("table entry %0d", n);
            chk(done == 1'b1, "R1 done", VLEN'(done), 1);
            chk(vd == exp_vd, "R2 data (table)", vd, exp_vd);
            chk(be == exp_be, "R6 enables (table)", VLEN'(be), VLEN'(exp_be));
            chk(vs_out == '0, "R9", VLEN'(vs_out), '0);
            @(negedge clk);
            chk(done == 1'b0, "R1 strobe width", VLEN'(done), '0);
        end

        // R1 outputs hold without a request while inputs move
        exp_vd = vd;
        old_vd = ~old_vd; res = ~res; vl = 5'd16; vs = 5'd0;
        repeat (3) @(negedge clk);
        chk(vd == exp_vd, "R1 hold", vd, exp_vd);

        // R3 vm=1: result independent of v0
        vm = 1; vta = 0; vma = 1; esz = 2'd1; vl = 5'd8; vs = 5'd2;
        v0 = '0;
        model();
        run_op();
        chk(vd == exp_vd && be == exp_be, "R3 v0 zero", vd, exp_vd);
        v0 = '1;
        run_op();
        chk(vd == exp_vd && be == exp_be, "R3 v0 ones", vd, exp_vd);

        // R7 prestart at the last element, byte elements
        vm = 0; vta = 1; vma = 1; esz = 2'd0; vl = 5'd16; vs = 5'd15; v0 = '0;
        model();
        run_op();
        chk(vd == exp_vd && be == 16'h8000, "R7 last element", VLEN'(be), 16'h8000);

        // R10 doubleword tail with body of one
        vm = 1; vta = 1; vma = 0; esz = 2'd3; vl = 5'd1; vs = 5'd0;
        model();
        run_op();
        chk(be == 16'hFFFF && vd[127:64] == {8{8'hFF}}, "R10 dword tail",
            VLEN'(be), 16'hFFFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule